// File: doc/BRIEF.md
# Token Ring Acknowledging Master

This block closes a one-way byte ring. Bytes from the last station come in on a receive port. Bytes for the first station leave on a transmit port. After reset the block places one empty token on the ring. Any token it receives goes straight on to the next station.

When a data frame comes round, the block works out the frame's checksum while the bytes stream through. It then writes the result into the frame's acknowledgement slot and sends the frame on, so that the frame reaches its sender again. The sender reads the acknowledgement to confirm delivery. The block also reports every well-formed frame it sees on a sideband port for the host: the source, the length and whether the checksum matched.

If the ring goes quiet for a set number of cycles, the block injects a fresh token. This recovers a token that was lost on the ring.

Top module: `ring_ack_master`

## Requirements
- R1: While reset is held, tx_valid_o and host_valid_o are 0. After reset is released, exactly one byte 0xA5 (the empty token) is sent within the first few cycles, and nothing else is sent until a byte arrives or the timeout expires.
- R2: A byte received outside a frame is sent out unchanged, two cycles after it was received. This covers the token 0xA5 and any stray byte other than 0x5A.
- R3: A frame is 0x5A, source, length N (1..MAX_LEN), N payload bytes, acknowledgement byte, checksum byte, all on consecutive valid cycles. Every frame byte except the acknowledgement byte is sent out unchanged, two cycles after it was received.
- R4: The checksum is the XOR of the source, length and payload bytes. When it equals the received checksum byte, the acknowledgement byte is sent as 0x01, whatever value it arrived with.
- R5: On a checksum mismatch, the acknowledgement byte is sent as 0x00. The checksum byte is always sent exactly as it was received and is never recomputed.
- R6: A length byte of 0 or above MAX_LEN ends frame parsing. That byte and the bytes after it are sent out unchanged, and no host report is made for the frame.
- R7: For each well-formed frame, host_valid_o is high for exactly one cycle. That cycle is the cycle in which the acknowledgement byte is on tx_data_o. In it, host_src_o and host_len_o carry the source and length bytes, and host_ok_o shows whether the checksum matched.
- R8: If neither a token nor a frame start is received for TIMEOUT cycles, one token 0xA5 is injected. No token is injected before that time.
- R9: An injected token uses only a transmit slot that no received byte occupies. tx_valid_o is high only for forwarded or injected bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A receive byte is present |
| rx_data_i | input | 8 | Receive byte from the last station |
| tx_valid_o | output | 1 | A transmit byte is present |
| tx_data_o | output | 8 | Transmit byte to the first station |
| host_valid_o | output | 1 | One-cycle frame report strobe |
| host_src_o | output | 8 | Source byte of the reported frame |
| host_len_o | output | 8 | Length byte of the reported frame |
| host_ok_o | output | 1 | The checksum of the reported frame matched |

## Verification
The bench builds the block with TIMEOUT set to 64 and MAX_LEN kept at 16. The short timeout lets a silent stretch reach a token injection in well under a hundred cycles, so the bench can check both the earliest and the latest cycle at which the injection may appear. The full MAX_LEN lets frames of 1 and 16 payload bytes run next to random frames, bad checksums and out-of-range lengths of 0 and 17.

// File: rtl/ring_master_pkg.sv
package ring_master_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] SYM_TOKEN = 8'hA5;
  localparam logic [BYTE_W-1:0] SYM_FRAME = 8'h5A;
  localparam logic [BYTE_W-1:0] ACK_GOOD  = 8'h01;
  localparam logic [BYTE_W-1:0] ACK_NONE  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_LEN,
    ST_PAY,
    ST_ACK,
    ST_CSUM
  } parse_st_e;
endpackage

// File: rtl/ring_frame_parser.sv
module ring_frame_parser
  import ring_master_pkg::*;
#(
  parameter int unsigned MAX_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              idle_o,
  output logic              activity_o,
  output logic              ack_slot_o,
  output logic              csum_slot_o,
  output logic              csum_ok_o,
  output logic [BYTE_W-1:0] src_o,
  output logic [BYTE_W-1:0] len_o
);
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);

  parse_st_e         st_q;
  logic [LEN_W-1:0]  rem_q;
  logic [BYTE_W-1:0] acc_q;
  logic [BYTE_W-1:0] src_q;
  logic [BYTE_W-1:0] len_q;
  logic              len_ok;

  assign len_ok      = (data_i != '0) && (data_i <= BYTE_W'(MAX_LEN));
  assign idle_o      = (st_q == ST_IDLE);
  assign activity_o  = valid_i && idle_o &&
                       ((data_i == SYM_TOKEN) || (data_i == SYM_FRAME));
  assign ack_slot_o  = valid_i && (st_q == ST_ACK);
  assign csum_slot_o = valid_i && (st_q == ST_CSUM);
  assign csum_ok_o   = (data_i == acc_q);
  assign src_o       = src_q;
  assign len_o       = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      acc_q <= '0;
      src_q <= '0;
      len_q <= '0;
    end else if (valid_i) begin
      unique case (st_q)
        ST_IDLE: if (data_i == SYM_FRAME) st_q <= ST_SRC;
        ST_SRC: begin
          src_q <= data_i;
          acc_q <= data_i;
          st_q  <= ST_LEN;
        end
        ST_LEN: begin
          if (len_ok) begin
            len_q <= data_i;
            rem_q <= data_i[LEN_W-1:0];
            acc_q <= acc_q ^ data_i;
            st_q  <= ST_PAY;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_PAY: begin
          acc_q <= acc_q ^ data_i;
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) st_q <= ST_ACK;
        end
        ST_ACK:  st_q <= ST_CSUM;
        ST_CSUM: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_token_watchdog.sv
module ring_token_watchdog #(
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  input  logic slot_free_i,
  output logic inject_o
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign inject_o = pend_q && slot_free_i;

  // pend_q resets high so the first token goes out right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (activity_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (inject_o) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (!pend_q) begin
      if (cnt_q == CNT_W'(TIMEOUT - 1)) pend_q <= 1'b1;
      else                              cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ring_tx_pipe.sv
module ring_tx_pipe
  import ring_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ack_slot_i,
  input  logic              inject_i,
  input  logic [BYTE_W-1:0] ack_val_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic              s1_valid_q;
  logic              s1_ack_q;
  logic [BYTE_W-1:0] s1_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_ack_q   <= 1'b0;
      s1_data_q  <= '0;
    end else begin
      s1_valid_q <= valid_i || inject_i;
      s1_ack_q   <= ack_slot_i;
      s1_data_q  <= valid_i ? data_i : SYM_TOKEN;
    end
  end

  // ack value resolves one cycle later, when the checksum byte is at the input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= s1_valid_q;
      tx_data_o  <= s1_ack_q ? ack_val_i : s1_data_q;
    end
  end
endmodule

// File: rtl/ring_ack_master.sv
module ring_ack_master
  import ring_master_pkg::*;
#(
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       host_valid_o,
  output logic [7:0] host_src_o,
  output logic [7:0] host_len_o,
  output logic       host_ok_o
);
  logic              parse_idle;
  logic              parse_act;
  logic              parse_ack;
  logic              parse_csum;
  logic              parse_ok;
  logic [BYTE_W-1:0] parse_src;
  logic [BYTE_W-1:0] parse_len;
  logic              inject;
  logic              frame_good;
  logic [BYTE_W-1:0] ack_val;

  ring_frame_parser #(.MAX_LEN(MAX_LEN)) u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .idle_o     (parse_idle),
    .activity_o (parse_act),
    .ack_slot_o (parse_ack),
    .csum_slot_o(parse_csum),
    .csum_ok_o  (parse_ok),
    .src_o      (parse_src),
    .len_o      (parse_len)
  );

  ring_token_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .activity_i (parse_act),
    .slot_free_i(!rx_valid_i),
    .inject_o   (inject)
  );

  assign frame_good = parse_csum && parse_ok;
  assign ack_val    = frame_good ? ACK_GOOD : ACK_NONE;

  ring_tx_pipe u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .data_i    (rx_data_i),
    .ack_slot_i(parse_ack),
    .inject_i  (inject),
    .ack_val_i (ack_val),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_valid_o <= 1'b0;
      host_src_o   <= '0;
      host_len_o   <= '0;
      host_ok_o    <= 1'b0;
    end else begin
      host_valid_o <= parse_csum;
      if (parse_csum) begin
        host_src_o <= parse_src;
        host_len_o <= parse_len;
        host_ok_o  <= parse_ok;
      end
    end
  end
endmodule

// File: rtl/ring_ack_master_chk.sv
module ring_ack_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       host_valid_o,
  input logic       host_ok_o,
  input logic       in_idle,
  input logic       ack_slot
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end
  assign warm = (age_q >= 2'd2);

  p_fwd_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(rx_valid_i, 2) |-> tx_valid_o);

  p_token_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(rx_valid_i && in_idle && rx_data_i == 8'hA5, 2) |-> tx_data_o == 8'hA5);

  p_byte_unchanged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(rx_valid_i && !ack_slot, 2) |-> tx_data_o == $past(rx_data_i, 2));

  p_ack_matches_report_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_o |-> tx_valid_o && tx_data_o == {7'd0, host_ok_o});

  p_report_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_o |=> !host_valid_o);

  p_inject_free_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && tx_valid_o && !$past(rx_valid_i, 2) |-> tx_data_o == 8'hA5);
endmodule

bind ring_ack_master ring_ack_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_data_i   (rx_data_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .host_valid_o(host_valid_o),
  .host_ok_o   (host_ok_o),
  .in_idle     (parse_idle),
  .ack_slot    (parse_ack)
);

// File: tb/ring_ack_master_tb.sv
module ring_ack_master_tb;
  localparam int TO = 64;
  localparam int ML = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       host_valid;
  logic [7:0] host_src;
  logic [7:0] host_len;
  logic       host_ok;

  ring_ack_master #(.MAX_LEN(ML), .TIMEOUT(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .host_valid_o(host_valid),
    .host_src_o(host_src), .host_len_o(host_len), .host_ok_o(host_ok)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;

  logic [7:0] exp_data[$];
  int         exp_at[$];
  string      exp_req[$];
  logic [7:0] hs_src[$];
  logic [7:0] hs_len[$];
  bit         hs_ok[$];
  int         hs_at[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] plain_byte();
    logic [7:0] b;
    b = 8'($urandom);
    if (b == 8'hA5 || b == 8'h5A) b = 8'h11;
    return b;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (tx_valid) begin
        if (exp_data.size() == 0) chk(1'b0, "R9", "unexpected tx byte", tx_data, -1);
        else begin
          logic [7:0] e; int a; string r;
          e = exp_data.pop_front(); a = exp_at.pop_front(); r = exp_req.pop_front();
          chk(tx_data == e, r, "tx byte", tx_data, e);
          chk(cyc == a, r, "tx cycle", cyc, a);
        end
      end
      if (host_valid) begin
        if (hs_src.size() == 0) chk(1'b0, "R7", "unexpected host report", host_src, -1);
        else begin
          logic [7:0] s, l; bit k; int a;
          s = hs_src.pop_front(); l = hs_len.pop_front(); k = hs_ok.pop_front(); a = hs_at.pop_front();
          chk(host_src == s, "R7", "host source", host_src, s);
          chk(host_len == l, "R7", "host length", host_len, l);
          chk(host_ok == k, "R7", "host ok", host_ok, k);
          chk(cyc == a, "R7", "host cycle", cyc, a);
        end
      end
    end
  end

  task automatic put(logic [7:0] b, logic [7:0] e, string r);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    exp_data.push_back(e); exp_at.push_back(cyc + 2); exp_req.push_back(r);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic send_frame(logic [7:0] src, int n, bit bad, logic [7:0] ack_in);
    logic [7:0] x, p, cs;
    x = src ^ 8'(n);
    put(8'h5A, 8'h5A, "R3");
    put(src, src, "R3");
    put(8'(n), 8'(n), "R3");
    for (int i = 0; i < n; i++) begin
      p = 8'($urandom);
      x ^= p;
      put(p, p, "R3");
    end
    cs = bad ? (x ^ 8'(1 + $urandom_range(254))) : x;
    put(ack_in, bad ? 8'h00 : 8'h01, bad ? "R5" : "R4");
    put(cs, cs, "R5");
    hs_src.push_back(src); hs_len.push_back(8'(n)); hs_ok.push_back(!bad); hs_at.push_back(cyc + 1);
  endtask

  task automatic send_bad_len(logic [7:0] len);
    logic [7:0] s;
    s = plain_byte();
    put(8'h5A, 8'h5A, "R6");
    put(s, s, "R6");
    put(len, len, "R6");
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int tok_n, inj_n, inj_cyc, last_tok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1", "tx_valid in reset", tx_valid, 0);
    chk(!host_valid, "R1", "host_valid in reset", host_valid, 0);
    rst_n = 1'b1;

    tok_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tx_valid) begin
        tok_n++;
        chk(tx_data == 8'hA5, "R1", "launch byte", tx_data, 8'hA5);
      end
    end
    chk(tok_n == 1, "R1", "launch token count", tok_n, 1);
    mon_on = 1'b1;

    // directed corners
    put(8'hA5, 8'hA5, "R2");
    send_frame(8'h03, 1, 1'b0, 8'h00);
    send_frame(8'h44, ML, 1'b0, 8'hFF);
    send_frame(8'h21, 4, 1'b1, 8'h01);
    send_bad_len(8'h00);
    send_bad_len(8'(ML + 1));
    put(8'h33, 8'h33, "R2");
    put(8'hA5, 8'hA5, "R2");
    idle(1);

    for (int it = 0; it < 60; it++) begin
      int kind;
      kind = $urandom_range(9);
      if (kind <= 5)      send_frame(plain_byte(), $urandom_range(ML - 1) + 1, 1'b0, 8'($urandom));
      else if (kind == 6) send_frame(plain_byte(), $urandom_range(ML - 1) + 1, 1'b1, 8'($urandom));
      else if (kind == 7) put(8'hA5, 8'hA5, "R2");
      else if (kind == 8) begin
        logic [7:0] s;
        s = plain_byte();
        put(s, s, "R2");
        put(8'hA5, 8'hA5, "R2");
      end else send_bad_len(($urandom_range(1) == 0) ? 8'h00 : 8'(ML + 1 + $urandom_range(200)));
      idle($urandom_range(2));
    end

    put(8'hA5, 8'hA5, "R2");
    last_tok = cyc;
    idle(1);
    for (int i = 0; i < 10 && exp_data.size() != 0; i++) @(negedge clk);
    chk(exp_data.size() == 0, "R3", "bytes left unsent", exp_data.size(), 0);
    chk(hs_src.size() == 0, "R7", "reports left unseen", hs_src.size(), 0);
    mon_on = 1'b0;

    inj_n = 0; inj_cyc = 0;
    while (cyc < last_tok + TO + 24) begin
      @(negedge clk);
      if (tx_valid) begin
        inj_n++;
        inj_cyc = cyc;
        chk(tx_data == 8'hA5, "R8", "injected byte", tx_data, 8'hA5);
      end
    end
    chk(inj_n == 1, "R8", "injected token count", inj_n, 1);
    chk(inj_cyc - last_tok >= TO, "R8", "injection too early", inj_cyc - last_tok, TO);
    chk(inj_cyc - last_tok <= TO + 8, "R8", "injection too late", inj_cyc - last_tok, TO + 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule